// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It reads a directory entry and then a table entry from memory through a single request/response port. A requester hands over the linear address, whether the access is a read or a write, whether it comes from user or supervisor code, the paging-enable flag and the frame number of the directory. The walker answers with either a one-cycle `done` pulse carrying the physical address, or a one-cycle `fault` pulse. On a fault, the faulting linear address stays latched until the next fault.

The linear address is split into three fields. Bits 31:22 index the directory. Bits 21:12 index the table that the directory entry points to. Bits 11:0 pass through as the byte offset within the 4 KB page. The directory and each table are 4 KB pages of 1024 four-byte entries. Every entry holds a frame number in bits 31:12 and attribute flags in its low bits. The walker combines the rights granted by both levels. On a successful walk it writes the accessed and dirty flags back to memory before it reports `done`. When paging is off, the address is returned unchanged and memory is not touched.

Top module: `pt_walker`

## Requirements
- R1: While `pg_en` is 0, an accepted request produces `done` on the clock edge that accepts it, with `phys_addr` equal to `req_lin`, and issues no memory request.
- R2: The first read goes to `{dir_base, req_lin[31:22], 2'b00}`. The second read goes to `{pde[31:12], req_lin[21:12], 2'b00}`, where pde is the word the first read returned.
- R3: On `done` after a walk, `phys_addr` equals `{pte[31:12], req_lin[11:0]}`.
- R4: An entry with bit 0 (present) clear gives a `fault` pulse with `fault_addr` equal to `req_lin`, no `done`, and no memory write. A directory entry that is not present stops the walk before the table read.
- R5: A user-mode write faults when bit 1 (writable) is clear in either the directory or the table entry. Supervisor writes ignore bit 1 at both levels.
- R6: A user-mode access faults when bit 2 (user) is clear in either entry. Supervisor accesses ignore bit 2.
- R7: A successful walk sets bit 5 (accessed) in both entries. A write also sets bit 6 (dirty) in the table entry. The directory entry is written before the table entry, and both writes complete before `done`.
- R8: An entry whose flags would not change is not written. A repeat of a walk that already set its flags performs no memory write.
- R9: Only one memory request is outstanding at a time. A request whose `mem_req_ready` is low is held with unchanged address and direction.
- R10: `fault_addr` changes only on the edge that raises `fault`. It keeps its value across successful walks.
- R11: `done` and `fault` are single-cycle pulses that never occur together. `req_ready` is low in the cycle either pulse is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| pg_en | input | 1 | Paging enable; 0 bypasses translation |
| dir_base | input | 20 | Frame number of the page directory |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_wdata | output | 32 | Updated entry for a write |
| mem_rsp_valid | input | 1 | Memory response (read data or write ack) |
| mem_rsp_ready | output | 1 | Walker is waiting for a response |
| mem_rsp_rdata | input | 32 | Read data |
| done | output | 1 | Translation finished (one cycle) |
| phys_addr | output | 32 | Physical address, valid with `done` |
| fault | output | 1 | Page fault (one cycle) |
| fault_addr | output | 32 | Latched linear address of the last fault |

## Verification
When paging is off, the result is due exactly one cycle after acceptance: `done` is registered on the accepting edge. The bench samples that cycle and no other. A walk takes a variable number of cycles, because the memory model answers one cycle after each handshake and can stall `mem_req_ready`. For walks, the bench waits at falling edges for the first `done` or `fault`. It then checks the result, the read addresses and the write-back count in the memory log. One cycle later it confirms that the pulse has dropped. Once a fault has been reported, `fault_addr` is compared against the faulting address again after later successful walks.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  // entry flag positions (fixed by the walker's decode)
  localparam int FLG_PRESENT = 0;
  localparam int FLG_WRITE   = 1;
  localparam int FLG_USER    = 2;
  localparam int FLG_ACCESS  = 5;
  localparam int FLG_DIRTY   = 6;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DIR_RQ,
    ST_DIR_RS,
    ST_TBL_RQ,
    ST_TBL_RS,
    ST_DIR_WQ,
    ST_DIR_WS,
    ST_TBL_WQ,
    ST_TBL_WS
  } walk_st_e;
endpackage

// File: rtl/pgw_perm.sv
module pgw_perm (
  input  logic dir_wr_ok,
  input  logic dir_usr_ok,
  input  logic tbl_wr_ok,
  input  logic tbl_usr_ok,
  input  logic is_user,
  input  logic is_write,
  output logic deny
);
  logic usr_ok, wr_ok;

  // both levels must grant a right for it to hold
  always_comb begin
    usr_ok = dir_usr_ok & tbl_usr_ok;
    wr_ok  = dir_wr_ok & tbl_wr_ok;
    deny   = is_user & (~usr_ok | (is_write & ~wr_ok));
  end
endmodule

// File: rtl/pgw_entry_upd.sv
module pgw_entry_upd #(
  parameter int EW = 32
) (
  input  logic [EW-1:0] ent_in,
  input  logic          mark_dirty,
  output logic [EW-1:0] ent_out,
  output logic          changed
);
  import pgw_pkg::*;

  logic [EW-1:0] set_mask;

  always_comb begin
    set_mask = '0;
    set_mask[FLG_ACCESS] = 1'b1;
    set_mask[FLG_DIRTY]  = mark_dirty;
    ent_out = ent_in | set_mask;
    changed = (ent_out != ent_in);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int AW    = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [AW-1:0]       req_lin,
  input  logic                req_write,
  input  logic                req_user,
  input  logic                pg_en,
  input  logic [AW-OFF_W-1:0] dir_base,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_we,
  output logic [AW-1:0]       mem_req_addr,
  output logic [AW-1:0]       mem_req_wdata,
  input  logic                mem_rsp_valid,
  output logic                mem_rsp_ready,
  input  logic [AW-1:0]       mem_rsp_rdata,
  output logic                done,
  output logic [AW-1:0]       phys_addr,
  output logic                fault,
  output logic [AW-1:0]       fault_addr
);
  import pgw_pkg::*;

  localparam int FRAME_W = AW - OFF_W;
  localparam int ENT_B   = OFF_W - IDX_W;   // log2 of entry size in bytes
  localparam int DIR_LO  = OFF_W + IDX_W;

  walk_st_e       state;
  logic [AW-1:0]  lin_q;
  logic           wr_q, usr_q;
  logic [FRAME_W-1:0] base_q;
  logic [AW-1:0]  dir_q, tbl_q, pte_addr_q;
  logic           tbl_chg_q;

  logic           mreq_v, mreq_we;
  logic [AW-1:0]  mreq_a, mreq_wd;
  logic           done_q, fault_q;
  logic [AW-1:0]  phys_q, fault_addr_q;

  logic [AW-1:0]  pde_addr_c, pte_addr_c, dir_new, tbl_new;
  logic           dir_chg, tbl_chg, deny;
  logic           rsp_hit;

  // entry addresses
  always_comb begin
    pde_addr_c = {base_q, lin_q[AW-1:DIR_LO], {ENT_B{1'b0}}};
    pte_addr_c = {mem_rsp_rdata[AW-1:OFF_W], lin_q[DIR_LO-1:OFF_W], {ENT_B{1'b0}}};
  end

  pgw_perm u_perm (
    .dir_wr_ok  (dir_q[FLG_WRITE]),
    .dir_usr_ok (dir_q[FLG_USER]),
    .tbl_wr_ok  (mem_rsp_rdata[FLG_WRITE]),
    .tbl_usr_ok (mem_rsp_rdata[FLG_USER]),
    .is_user    (usr_q),
    .is_write   (wr_q),
    .deny       (deny)
  );

  pgw_entry_upd #(.EW(AW)) u_dir_upd (
    .ent_in     (dir_q),
    .mark_dirty (1'b0),
    .ent_out    (dir_new),
    .changed    (dir_chg)
  );

  pgw_entry_upd #(.EW(AW)) u_tbl_upd (
    .ent_in     (mem_rsp_rdata),
    .mark_dirty (wr_q),
    .ent_out    (tbl_new),
    .changed    (tbl_chg)
  );

  assign rsp_hit = mem_rsp_valid & mem_rsp_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      lin_q        <= '0;
      wr_q         <= 1'b0;
      usr_q        <= 1'b0;
      base_q       <= '0;
      dir_q        <= '0;
      tbl_q        <= '0;
      pte_addr_q   <= '0;
      tbl_chg_q    <= 1'b0;
      mreq_v       <= 1'b0;
      mreq_we      <= 1'b0;
      mreq_a       <= '0;
      mreq_wd      <= '0;
      done_q       <= 1'b0;
      fault_q      <= 1'b0;
      phys_q       <= '0;
      fault_addr_q <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            lin_q  <= req_lin;
            wr_q   <= req_write;
            usr_q  <= req_user;
            base_q <= dir_base;
            if (!pg_en) begin
              phys_q <= req_lin;
              done_q <= 1'b1;
            end else begin
              mreq_v  <= 1'b1;
              mreq_we <= 1'b0;
              mreq_a  <= {dir_base, req_lin[AW-1:DIR_LO], {ENT_B{1'b0}}};
              state   <= ST_DIR_RQ;
            end
          end
        end
        ST_DIR_RQ: begin
          if (mem_req_ready) begin
            mreq_v <= 1'b0;
            state  <= ST_DIR_RS;
          end
        end
        ST_DIR_RS: begin
          if (rsp_hit) begin
            dir_q <= mem_rsp_rdata;
            if (!mem_rsp_rdata[FLG_PRESENT]) begin
              fault_q      <= 1'b1;
              fault_addr_q <= lin_q;
              state        <= ST_IDLE;
            end else begin
              mreq_v     <= 1'b1;
              mreq_we    <= 1'b0;
              mreq_a     <= pte_addr_c;
              pte_addr_q <= pte_addr_c;
              state      <= ST_TBL_RQ;
            end
          end
        end
        ST_TBL_RQ: begin
          if (mem_req_ready) begin
            mreq_v <= 1'b0;
            state  <= ST_TBL_RS;
          end
        end
        ST_TBL_RS: begin
          if (rsp_hit) begin
            if (!mem_rsp_rdata[FLG_PRESENT] || deny) begin
              fault_q      <= 1'b1;
              fault_addr_q <= lin_q;
              state        <= ST_IDLE;
            end else begin
              phys_q    <= {mem_rsp_rdata[AW-1:OFF_W], lin_q[OFF_W-1:0]};
              tbl_q     <= tbl_new;
              tbl_chg_q <= tbl_chg;
              if (dir_chg) begin
                mreq_v  <= 1'b1;
                mreq_we <= 1'b1;
                mreq_a  <= pde_addr_c;
                mreq_wd <= dir_new;
                state   <= ST_DIR_WQ;
              end else if (tbl_chg) begin
                mreq_v  <= 1'b1;
                mreq_we <= 1'b1;
                mreq_a  <= pte_addr_q;
                mreq_wd <= tbl_new;
                state   <= ST_TBL_WQ;
              end else begin
                done_q <= 1'b1;
                state  <= ST_IDLE;
              end
            end
          end
        end
        ST_DIR_WQ: begin
          if (mem_req_ready) begin
            mreq_v <= 1'b0;
            state  <= ST_DIR_WS;
          end
        end
        ST_DIR_WS: begin
          if (rsp_hit) begin
            if (tbl_chg_q) begin
              mreq_v  <= 1'b1;
              mreq_we <= 1'b1;
              mreq_a  <= pte_addr_q;
              mreq_wd <= tbl_q;
              state   <= ST_TBL_WQ;
            end else begin
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end
          end
        end
        ST_TBL_WQ: begin
          if (mem_req_ready) begin
            mreq_v <= 1'b0;
            state  <= ST_TBL_WS;
          end
        end
        ST_TBL_WS: begin
          if (rsp_hit) begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready     = (state == ST_IDLE) && !done_q && !fault_q;
    mem_rsp_ready = (state == ST_DIR_RS) || (state == ST_TBL_RS) ||
                    (state == ST_DIR_WS) || (state == ST_TBL_WS);
    mem_req_valid = mreq_v;
    mem_req_we    = mreq_we;
    mem_req_addr  = mreq_a;
    mem_req_wdata = mreq_wd;
    done          = done_q;
    fault         = fault_q;
    phys_addr     = phys_q;
    fault_addr    = fault_addr_q;
  end
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_lin,
  input logic          pg_en,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic [AW-1:0] mem_req_addr,
  input logic          mem_rsp_valid,
  input logic          mem_rsp_ready,
  input logic          done,
  input logic [AW-1:0] phys_addr,
  input logic          fault,
  input logic [AW-1:0] fault_addr
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else if (mem_req_valid && mem_req_ready) pend <= 1'b1;
    else if (mem_rsp_valid && mem_rsp_ready) pend <= 1'b0;
  end

  p_bypass_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !pg_en) |=> (done && phys_addr == $past(req_lin)));

  p_single_out_r9: assert property (@(posedge clk) disable iff (rst)
    pend |-> !mem_req_valid);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

  p_fault_addr_hold_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (fault || $stable(fault_addr)));

  p_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(done && fault));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_fault_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    fault |=> !fault);
endmodule

bind pt_walker pgw_checker #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_lin       (req_lin),
  .pg_en         (pg_en),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_ready (mem_rsp_ready),
  .done          (done),
  .phys_addr     (phys_addr),
  .fault         (fault),
  .fault_addr    (fault_addr)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;   // 50 MHz

  logic        req_valid = 1'b0, req_ready, req_write = 1'b0, req_user = 1'b0, pg_en = 1'b0;
  logic [31:0] req_lin = '0;
  logic [19:0] dir_base = 20'h00001;
  logic        mem_req_valid, mem_req_ready, mem_req_we, mem_rsp_ready;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        rsp_v;
  logic [31:0] rsp_d;
  logic        done, fault;
  logic [31:0] phys_addr, fault_addr;

  pt_walker u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_lin(req_lin), .req_write(req_write), .req_user(req_user),
    .pg_en(pg_en), .dir_base(dir_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(rsp_v),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_rdata(rsp_d),
    .done(done), .phys_addr(phys_addr), .fault(fault), .fault_addr(fault_addr)
  );

  // ---------------- memory model ----------------
  logic [31:0] mem [0:4095];
  logic [31:0] rd_log [0:7];
  logic [31:0] wr_log [0:7];
  int          n_rd, n_wr, cyc;
  logic        bd_we = 1'b0;
  logic [11:0] bd_idx = '0;
  logic [31:0] bd_data = '0;
  logic        ready_full = 1'b1;

  assign mem_req_ready = ready_full | cyc[0];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      for (int i = 0; i < 4096; i++) mem[i] <= '0;
      rsp_v <= 1'b0;
      rsp_d <= '0;
      n_rd  <= 0;
      n_wr  <= 0;
    end else begin
      if (rsp_v && mem_rsp_ready) rsp_v <= 1'b0;
      if (bd_we) mem[bd_idx] <= bd_data;
      else if (mem_req_valid && mem_req_ready) begin
        if (mem_req_we) begin
          mem[mem_req_addr[13:2]] <= mem_req_wdata;
          wr_log[n_wr % 8] <= mem_req_addr;
          n_wr <= n_wr + 1;
        end else begin
          rsp_d <= mem[mem_req_addr[13:2]];
          rd_log[n_rd % 8] <= mem_req_addr;
          n_rd <= n_rd + 1;
        end
        rsp_v <= 1'b1;
      end
    end
  end

  // ---------------- checking helpers ----------------
  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bd_we = 1'b1; bd_idx = a[13:2]; bd_data = d;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  logic        r_done, r_fault, r_clean;
  logic [31:0] r_phys;
  int          r_cyc, rd0, wr0;

  task automatic walk(input logic [31:0] lin, input logic wr, input logic usr, input logic pg);
    @(negedge clk);
    rd0 = n_rd; wr0 = n_wr;
    req_valid = 1'b1; req_lin = lin; req_write = wr; req_user = usr; pg_en = pg;
    @(negedge clk);
    req_valid = 1'b0;
    r_cyc = 1;
    while (!(done || fault) && r_cyc < 500) begin
      @(negedge clk);
      r_cyc++;
    end
    r_done = done; r_fault = fault; r_phys = phys_addr;
    chk(req_ready == 1'b0, "R11 ready low during pulse", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    r_clean = !done && !fault;
    chk(r_clean, "R11 pulse lasts one cycle", {30'd0, done, fault}, 32'd0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(req_ready == 1'b1, "R11 reset ready", {31'd0, req_ready}, 32'd1);
    chk(!done && !fault, "R11 reset pulses", {30'd0, done, fault}, 32'd0);
    chk(mem_req_valid == 1'b0, "R9 reset no request", {31'd0, mem_req_valid}, 32'd0);
    chk(fault_addr == 32'd0, "R10 reset fault_addr", fault_addr, 32'd0);
  endtask

  task automatic t_bypass();
    walk(32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0);
    chk(r_done && r_cyc == 1, "R1 done next cycle", r_cyc, 32'd1);
    chk(r_phys == 32'hDEAD_BEEF, "R1 address unchanged", r_phys, 32'hDEAD_BEEF);
    chk(n_rd == rd0 && n_wr == wr0, "R1 no memory access", n_rd - rd0 + n_wr - wr0, 32'd0);
  endtask

  task automatic t_first_walk();
    poke(32'h100C, 32'h0000_2007);
    poke(32'h2014, 32'hABCD_E007);
    walk(32'h00C0_5123, 1'b0, 1'b0, 1'b1);
    chk(r_done && !r_fault, "R3 walk completes", {30'd0, r_done, r_fault}, 32'd2);
    chk(rd_log[rd0 % 8] == 32'h100C, "R2 directory address", rd_log[rd0 % 8], 32'h100C);
    chk(rd_log[(rd0 + 1) % 8] == 32'h2014, "R2 table address", rd_log[(rd0 + 1) % 8], 32'h2014);
    chk(r_phys == 32'hABCD_E123, "R3 physical address", r_phys, 32'hABCD_E123);
    chk(mem[12'h403] == 32'h0000_2027, "R7 directory accessed", mem[12'h403], 32'h0000_2027);
    chk(mem[12'h805] == 32'hABCD_E027, "R7 table accessed no dirty", mem[12'h805], 32'hABCD_E027);
    chk(n_wr - wr0 == 2 && wr_log[wr0 % 8] == 32'h100C, "R7 two writes directory first",
        wr_log[wr0 % 8], 32'h100C);
  endtask

  task automatic t_dirty_then_clean();
    walk(32'h00C0_5123, 1'b1, 1'b0, 1'b1);
    chk(mem[12'h805] == 32'hABCD_E067, "R7 dirty set on write", mem[12'h805], 32'hABCD_E067);
    chk(n_wr - wr0 == 1 && wr_log[wr0 % 8] == 32'h2014, "R8 only table written",
        n_wr - wr0, 32'd1);
    walk(32'h00C0_5123, 1'b0, 1'b0, 1'b1);
    chk(r_done && n_wr == wr0, "R8 repeat walk writes nothing", n_wr - wr0, 32'd0);
  endtask

  task automatic t_not_present();
    walk(32'h01C0_0456, 1'b0, 1'b0, 1'b1);
    chk(r_fault && !r_done, "R4 dir absent faults", {30'd0, r_done, r_fault}, 32'd1);
    chk(fault_addr == 32'h01C0_0456, "R4 fault address latched", fault_addr, 32'h01C0_0456);
    chk(n_rd - rd0 == 1 && n_wr == wr0, "R4 stops after directory", n_rd - rd0, 32'd1);
    poke(32'h1010, 32'h0000_3007);
    walk(32'h0100_9010, 1'b1, 1'b0, 1'b1);
    chk(r_fault && !r_done, "R4 table absent faults", {30'd0, r_done, r_fault}, 32'd1);
    chk(n_rd - rd0 == 2 && n_wr == wr0, "R4 no write-back on fault", n_wr - wr0, 32'd0);
    chk(mem[12'h404] == 32'h0000_3007, "R4 directory untouched", mem[12'h404], 32'h0000_3007);
  endtask

  task automatic t_write_protect();
    poke(32'h1020, 32'h0000_3005);
    poke(32'h3004, 32'h1111_1007);
    walk(32'h0200_1ABC, 1'b1, 1'b1, 1'b1);
    chk(r_fault && n_wr == wr0, "R5 user write to read-only faults", {31'd0, r_fault}, 32'd1);
    walk(32'h0200_1ABC, 1'b1, 1'b0, 1'b1);
    chk(r_done && r_phys == 32'h1111_1ABC, "R5 supervisor write allowed", r_phys, 32'h1111_1ABC);
    walk(32'h0200_1ABC, 1'b0, 1'b1, 1'b1);
    chk(r_done && !r_fault, "R5 user read allowed", {30'd0, r_done, r_fault}, 32'd2);
  endtask

  task automatic t_user_protect();
    poke(32'h3008, 32'h2222_2003);
    walk(32'h0200_2007, 1'b0, 1'b1, 1'b1);
    chk(r_fault && fault_addr == 32'h0200_2007, "R6 user access to supervisor page faults",
        fault_addr, 32'h0200_2007);
    walk(32'h0200_2007, 1'b0, 1'b0, 1'b1);
    chk(r_done && r_phys == 32'h2222_2007, "R6 supervisor access allowed", r_phys, 32'h2222_2007);
    chk(fault_addr == 32'h0200_2007, "R10 fault address held", fault_addr, 32'h0200_2007);
  endtask

  task automatic t_stall();
    ready_full = 1'b0;
    poke(32'h2018, 32'h0BEE_F007);
    walk(32'h00C0_6FFF, 1'b1, 1'b0, 1'b1);
    chk(r_done && r_phys == 32'h0BEE_FFFF, "R9 walk under stalls", r_phys, 32'h0BEE_FFFF);
    chk(mem[12'h806] == 32'h0BEE_F067, "R9 write-back under stalls", mem[12'h806], 32'h0BEE_F067);
    chk(n_rd - rd0 == 2 && n_wr - wr0 == 1, "R9 each request taken once", n_rd - rd0, 32'd2);
    ready_full = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_first_walk();
    t_dirty_then_clean();
    t_not_present();
    t_write_protect();
    t_user_protect();
    t_stall();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule